// File: doc/BRIEF.md
# Regulator Fault-Hiccup Start-Up Sequencer

This block is the digital supervisor of a switching regulator. It runs on the switching-cycle clock and decides, once per cycle, whether the power stage may switch and whether the soft-start capacitor is being charged or emptied. It waits for the supply to be good and for the regulator to be enabled. It then drives a soft-start ramp and holds normal operation once the ramp reports completion. Consecutive per-cycle undervoltage and overcurrent reports are counted in small counters. When one of them overflows, the stage is shut down. After a programmable cool-down delay the ramp is retried, and this repeats for as long as the fault persists.

The controller has five one-hot states. OFF is idle with the capacitor already empty. DISCHARGE empties the capacitor for a fixed 256 cycles. SOFTSTART switches and charges the capacitor. RUN switches normally. FAULT_DELAY holds the stage off for the cool-down interval. Its transitions are:
- OFF→SOFTSTART when qualified (supply good and enabled).
- DISCHARGE→OFF or DISCHARGE→SOFTSTART when the 256 cycles end.
- SOFTSTART→RUN on ramp completion.
- SOFTSTART→FAULT_DELAY and RUN→FAULT_DELAY on a counter overflow.
- FAULT_DELAY→SOFTSTART when the delay expires.
- SOFTSTART, RUN or FAULT_DELAY→DISCHARGE when qualification is lost.

Top module: `hiccup_seq`

## Requirements
- R1: While reset is low, the state is DISCHARGE, the switch enable is 0, the charge command is 0 and the discharge command is 1.
- R2: DISCHARGE lasts exactly 256 cycles from entry, whatever the qualification does meanwhile. It then goes to SOFTSTART if supply_ok and enable are both 1, otherwise to OFF.
- R3: OFF stays OFF until supply_ok and enable are both 1 in the same cycle, and then moves to SOFTSTART at the next edge.
- R4: With supply_ok or enable low, SOFTSTART, RUN and FAULT_DELAY move to DISCHARGE at the next edge. The switch enable is 0 in any cycle where supply_ok is 0.
- R5: SOFTSTART drives switch enable and charge command high. RUN drives switch enable alone. DISCHARGE and FAULT_DELAY drive only the discharge command. OFF drives none. SOFTSTART moves to RUN on ss_done.
- R6: In SOFTSTART or RUN, the 8th consecutive cycle of uv_below moves the state to FAULT_DELAY. Only a cycle with uv_recovered breaks the run. A cycle with neither flag keeps the count.
- R7: In SOFTSTART or RUN, the 7th consecutive cycle of oc_over moves the state to FAULT_DELAY. Any cycle without oc_over clears the count.
- R8: FAULT_DELAY lasts N cycles, where N is the delay_len value sampled while reset was low (0 acts as 1). It then moves to SOFTSTART. Changes to delay_len after reset have no effect.
- R9: Both fault counts are cleared on entry to FAULT_DELAY and stay clear outside SOFTSTART and RUN. Each retry therefore needs a full run of fault cycles before the next shutdown.
- R10: state_o is one-hot with OFF=bit 0, DISCHARGE=bit 1, SOFTSTART=bit 2, RUN=bit 3, FAULT_DELAY=bit 4.
- R11: Loss of qualification takes priority over a fault overflow, and a fault overflow takes priority over ss_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | switching-cycle clock |
| rst_n | input | 1 | synchronous active-low reset |
| delay_len | input | 16 | cool-down length in cycles, sampled during reset |
| supply_ok | input | 1 | supply above its power-on level |
| enable | input | 1 | regulator enable |
| uv_below | input | 1 | feedback below undervoltage trip this cycle |
| uv_recovered | input | 1 | feedback above undervoltage recovery level this cycle |
| oc_over | input | 1 | sampled current above limit this cycle |
| ss_done | input | 1 | soft-start ramp has reached the reference |
| sw_en | output | 1 | power switches allowed to operate |
| ss_charge | output | 1 | charge the soft-start capacitor |
| ss_discharge | output | 1 | discharge the soft-start capacitor |
| state_o | output | 5 | one-hot current state |

## Verification
State, charge and discharge outputs change at the first rising edge after the stimulus. The one exception is the switch enable, which falls in the same cycle that supply_ok falls. The bench changes inputs 1 ns after an edge and samples 1 ns after the next edge, so every table row checks exactly one edge's result. Timed phases are checked on the last cycle before they end and on the cycle after: 255 and 256 edges for the discharge, and N-1 and N edges for the cool-down. The fault runs are checked the same way, at the 7th and 8th undervoltage cycle and at the 6th and 7th overcurrent cycle.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

    typedef enum logic [4:0] {
        ST_OFF   = 5'b00001,
        ST_DISCH = 5'b00010,
        ST_SOFT  = 5'b00100,
        ST_RUN   = 5'b01000,
        ST_FDLY  = 5'b10000
    } seq_state_e;

    localparam int FAULT_CNT_W   = 3;
    localparam int DISCH_CYCLES  = 256;
    localparam int DELAY_W       = 16;

endpackage

// File: rtl/hiccup_fault_cnt.sv
module hiccup_fault_cnt #(
    parameter int CNT_W   = 3,
    parameter int TRIP_AT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic hit,
    input  logic clear,
    output logic trip
);
    localparam logic [CNT_W-1:0] CMAX   = '1;
    localparam logic [CNT_W-1:0] TRIP_V = CNT_W'(TRIP_AT);

    logic [CNT_W-1:0] count;

    assign trip = active & hit & ~clear & (count == TRIP_V);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!active || trip || clear) begin
            count <= '0;
        end else if (hit && count != CMAX) begin
            count <= count + 1'b1;
        end
    end

    // R9
    inactive_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> count == '0);

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= TRIP_V);

    // R6
    consec_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && hit && !clear && count < TRIP_V) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/hiccup_phase_tmr.sv
module hiccup_phase_tmr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (count != TOP) begin
            count <= count + 1'b1;
        end
    end

    // R8
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> count == '0);

endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
    import hiccup_pkg::*;
#(
    parameter int TMR_W      = 16,
    parameter int DIS_CYCLES = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             enable,
    input  logic             uv_trip,
    input  logic             oc_trip,
    input  logic             ss_done,
    input  logic [TMR_W-1:0] tmr_cnt,
    input  logic [TMR_W-1:0] dly_last,
    output seq_state_e       st,
    output logic             restart,
    output logic             counting,
    output logic             sw_en,
    output logic             ss_charge,
    output logic             ss_discharge
);
    localparam logic [TMR_W-1:0] DIS_LAST = TMR_W'(DIS_CYCLES - 1);

    seq_state_e nxt;
    logic       qual;
    logic       fault;

    assign qual     = supply_ok & enable;
    assign fault    = uv_trip | oc_trip;
    assign restart  = (nxt != st);
    assign counting = qual & ((st == ST_SOFT) | (st == ST_RUN));

    always_comb begin
        nxt = st;
        unique case (st)
            ST_OFF: begin
                if (qual) nxt = ST_SOFT;
            end
            ST_DISCH: begin
                if (tmr_cnt == DIS_LAST) nxt = qual ? ST_SOFT : ST_OFF;
            end
            ST_SOFT: begin
                if (!qual)        nxt = ST_DISCH;
                else if (fault)   nxt = ST_FDLY;
                else if (ss_done) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!qual)      nxt = ST_DISCH;
                else if (fault) nxt = ST_FDLY;
            end
            ST_FDLY: begin
                if (!qual)                  nxt = ST_DISCH;
                else if (tmr_cnt == dly_last) nxt = ST_SOFT;
            end
            default: nxt = ST_DISCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_DISCH;
        else        st <= nxt;
    end

    always_comb begin
        sw_en        = 1'b0;
        ss_charge    = 1'b0;
        ss_discharge = 1'b0;
        unique case (st)
            ST_OFF:   ;
            ST_DISCH: ss_discharge = 1'b1;
            ST_SOFT: begin
                sw_en     = supply_ok;
                ss_charge = 1'b1;
            end
            ST_RUN:   sw_en = supply_ok;
            ST_FDLY:  ss_discharge = 1'b1;
            default:  ss_discharge = 1'b1;
        endcase
    end

    // R10
    onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st) == 1);

    // R4
    qual_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!qual && (st == ST_SOFT || st == ST_RUN || st == ST_FDLY)) |=> st == ST_DISCH);

    // R3
    off_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF && qual) |=> st == ST_SOFT);

    // R2
    disch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DISCH && tmr_cnt != DIS_LAST) |=> st == ST_DISCH);

    // R6
    fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && (uv_trip || oc_trip)) |=> st == ST_FDLY);

endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq
    import hiccup_pkg::*;
#(
    parameter int CNT_W      = FAULT_CNT_W,
    parameter int DIS_CYCLES = DISCH_CYCLES,
    parameter int DLY_W      = DELAY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] delay_len,
    input  logic             supply_ok,
    input  logic             enable,
    input  logic             uv_below,
    input  logic             uv_recovered,
    input  logic             oc_over,
    input  logic             ss_done,
    output logic             sw_en,
    output logic             ss_charge,
    output logic             ss_discharge,
    output logic [4:0]       state_o
);
    localparam int DIS_W   = $clog2(DIS_CYCLES) + 1;
    localparam int TMR_W   = (DLY_W > DIS_W) ? DLY_W : DIS_W;
    localparam int CNT_TOP = (1 << CNT_W) - 1;
    localparam int UV_AT   = CNT_TOP;
    localparam int OC_AT   = CNT_TOP - 1;

    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] dly_m1;
    logic [TMR_W-1:0] dly_last;
    logic [TMR_W-1:0] tmr_cnt;
    logic             restart;
    logic             counting;
    logic             uv_trip;
    logic             oc_trip;
    seq_state_e       st;

    always_ff @(posedge clk) begin
        if (!rst_n) dly_q <= delay_len;
    end

    assign dly_m1   = (dly_q == '0) ? '0 : dly_q - 1'b1;
    assign dly_last = TMR_W'(dly_m1);

    hiccup_phase_tmr #(.W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .count   (tmr_cnt)
    );

    hiccup_fault_cnt #(.CNT_W(CNT_W), .TRIP_AT(UV_AT)) u_uv_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (counting),
        .hit    (uv_below),
        .clear  (uv_recovered),
        .trip   (uv_trip)
    );

    hiccup_fault_cnt #(.CNT_W(CNT_W), .TRIP_AT(OC_AT)) u_oc_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (counting),
        .hit    (oc_over),
        .clear  (~oc_over),
        .trip   (oc_trip)
    );

    hiccup_fsm #(.TMR_W(TMR_W), .DIS_CYCLES(DIS_CYCLES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .enable       (enable),
        .uv_trip      (uv_trip),
        .oc_trip      (oc_trip),
        .ss_done      (ss_done),
        .tmr_cnt      (tmr_cnt),
        .dly_last     (dly_last),
        .st           (st),
        .restart      (restart),
        .counting     (counting),
        .sw_en        (sw_en),
        .ss_charge    (ss_charge),
        .ss_discharge (ss_discharge)
    );

    assign state_o = st;

    // R4
    sw_off_no_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> !sw_en);

    // R5
    charge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ss_charge && ss_discharge));

endmodule

// File: tb/hiccup_seq_test.sv
`timescale 1ns/1ps
module hiccup_seq_test;
    localparam logic [4:0] S_OFF = 5'b00001;
    localparam logic [4:0] S_DIS = 5'b00010;
    localparam logic [4:0] S_SS  = 5'b00100;
    localparam logic [4:0] S_RUN = 5'b01000;
    localparam logic [4:0] S_FD  = 5'b10000;

    // row: [22:15] repeat, [14:11] requirement, [10:5] ok,en,uvb,uvr,oc,done, [4:0] state after each edge
    localparam int NV = 33;
    localparam logic [22:0] VEC [NV] = '{
        {8'd7, 4'd6,  6'b111000, S_SS },  // R6 seven below
        {8'd1, 4'd6,  6'b110100, S_SS },  // R6 recovered clears
        {8'd7, 4'd6,  6'b111000, S_SS },
        {8'd1, 4'd6,  6'b110000, S_SS },  // R6 band holds
        {8'd1, 4'd6,  6'b111000, S_FD },  // R6 eighth trips
        {8'd4, 4'd8,  6'b110000, S_FD },  // R8
        {8'd1, 4'd8,  6'b110000, S_SS },
        {8'd6, 4'd7,  6'b110010, S_SS },  // R7
        {8'd1, 4'd7,  6'b110000, S_SS },  // R7 clear
        {8'd6, 4'd7,  6'b110010, S_SS },
        {8'd1, 4'd7,  6'b110010, S_FD },  // R7 seventh trips
        {8'd4, 4'd9,  6'b110010, S_FD },  // R9 ignored in delay
        {8'd1, 4'd9,  6'b110010, S_SS },
        {8'd6, 4'd9,  6'b110010, S_SS },  // R9 full run again
        {8'd1, 4'd9,  6'b110010, S_FD },
        {8'd4, 4'd8,  6'b110000, S_FD },
        {8'd1, 4'd8,  6'b110000, S_SS },
        {8'd1, 4'd5,  6'b110001, S_RUN},  // R5
        {8'd6, 4'd7,  6'b110010, S_RUN},
        {8'd1, 4'd7,  6'b110011, S_FD },
        {8'd4, 4'd8,  6'b110000, S_FD },
        {8'd1, 4'd8,  6'b110000, S_SS },
        {8'd6, 4'd11, 6'b110010, S_SS },  // R11
        {8'd1, 4'd11, 6'b110011, S_FD },
        {8'd4, 4'd8,  6'b110000, S_FD },
        {8'd1, 4'd8,  6'b110000, S_SS },
        {8'd1, 4'd5,  6'b110001, S_RUN},
        {8'd7, 4'd6,  6'b111000, S_RUN},
        {8'd1, 4'd6,  6'b111000, S_FD },
        {8'd4, 4'd8,  6'b110000, S_FD },
        {8'd1, 4'd8,  6'b110000, S_SS },
        {8'd1, 4'd5,  6'b110001, S_RUN},
        {8'd1, 4'd4,  6'b100000, S_DIS}   // R4 enable low
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] delay_len = 16'd5;
    logic        supply_ok = 1'b0, enable = 1'b0, uv_below = 1'b0;
    logic        uv_recovered = 1'b0, oc_over = 1'b0, ss_done = 1'b0;
    logic        sw_en, ss_charge, ss_discharge;
    logic [4:0]  state_o;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    hiccup_seq uut (
        .clk(clk), .rst_n(rst_n), .delay_len(delay_len),
        .supply_ok(supply_ok), .enable(enable), .uv_below(uv_below),
        .uv_recovered(uv_recovered), .oc_over(oc_over), .ss_done(ss_done),
        .sw_en(sw_en), .ss_charge(ss_charge), .ss_discharge(ss_discharge),
        .state_o(state_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic [5:0] v);
        {supply_ok, enable, uv_below, uv_recovered, oc_over, ss_done} = v;
    endtask

    // expected outputs per R5 and R4: {state, sw_en, charge, discharge}
    task automatic check_state(input string tag, input logic [4:0] exp);
        logic [7:0] e;
        logic [7:0] a;
        e = {exp, ((exp == S_SS) || (exp == S_RUN)) && supply_ok,
             exp == S_SS, (exp == S_DIS) || (exp == S_FD)};
        a = {state_o, sw_en, ss_charge, ss_discharge};
        checks++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, a, e);
        end
    endtask

    task automatic do_reset(input logic [15:0] dl);
        rst_n = 1'b0;
        delay_len = dl;
        drive(6'b000000);
        repeat (2) step();
        rst_n = 1'b1;
    endtask

    task automatic run_check(input int n, input logic [4:0] exp, input string tag);
        for (int i = 0; i < n; i++) begin
            step();
            check_state(tag, exp);
        end
    endtask

    initial begin
        #1;
        do_reset(16'd5);
        rst_n = 1'b0;
        check_state("R1 reset state", S_DIS);
        rst_n = 1'b1;

        repeat (255) step();
        check_state("R2 discharge held 255", S_DIS);
        step();
        check_state("R2 discharge to OFF", S_OFF);

        drive(6'b100000);
        run_check(3, S_OFF, "R3 supply only");
        drive(6'b010000);
        run_check(2, S_OFF, "R3 enable only");
        drive(6'b110000);
        step();
        check_state("R3 OFF to SOFTSTART", S_SS);

        for (int r = 0; r < NV; r++) begin
            drive(VEC[r][10:5]);
            for (int k = 0; k < int'(VEC[r][22:15]); k++) begin
                step();
                check_state($sformatf("R%0d row %0d", VEC[r][14:11], r), VEC[r][4:0]);
            end
        end

        drive(6'b110000);
        repeat (255) step();
        check_state("R2 discharge held qualified", S_DIS);
        step();
        check_state("R2 discharge to SOFTSTART", S_SS);

        supply_ok = 1'b0;
        #1;
        check_state("R4 sw_en drops with supply", S_SS);
        step();
        check_state("R4 supply loss to DISCHARGE", S_DIS);

        drive(6'b110000);
        repeat (256) step();
        drive(6'b110010);
        run_check(6, S_SS, "R7 count");
        run_check(1, S_FD, "R7 trip");
        drive(6'b100000);
        step();
        check_state("R4 enable loss in delay", S_DIS);

        do_reset(16'd3);
        delay_len = 16'd40;
        drive(6'b110000);
        repeat (256) step();
        check_state("R8 start after reset", S_SS);
        drive(6'b110010);
        repeat (7) step();
        check_state("R8 trip", S_FD);
        drive(6'b110000);
        run_check(2, S_FD, "R8 latched delay 3");
        run_check(1, S_SS, "R8 latched delay end");

        do_reset(16'd0);
        drive(6'b110000);
        repeat (256) step();
        drive(6'b110010);
        repeat (7) step();
        check_state("R8 trip zero delay", S_FD);
        drive(6'b110000);
        run_check(1, S_SS, "R8 zero delay acts as one");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule